// File: doc/BRIEF.md
# Multi-Queue Ethernet DMA Control Register File

This block is the software-facing control and status register file of a multi-queue Ethernet DMA engine. A host reaches it through a plain word bus (byte address, write strobe, write data, read strobe, read data). Every word in the 4 KiB window has an access class: read-write, write-only, read-only or write-one-to-clear. Words that no register occupies read zero and ignore writes.

Writes have side effects. A write to the transmit or receive halt word clears the written halt flags and sends a one-cycle kick to each addressed queue's ring walker. A receive queue is kicked only if it was not already halted. Writing a descriptor ring base also loads the matching ring pointer. The event register gathers strobes from the datapath and drives three interrupt lines through a mask: transmit-frame, receive-frame and an error class. Writing ones to the event register clears those events. The ring walkers, the management interface and the MAC datapath lie outside the block. They see it only through the kick pulses, the pointer outputs and the event and halt strobes.

Top module: `dmaq_regfile`

## Requirements
- R1: After synchronous reset, every register reads zero except the identity word, which reads the ID_VALUE parameter. All kick pulses, interrupt lines and the doorbell output are low.
- R2: The doorbell (word 6) is write-only. A read of it returns zero. A write to it places the written value on the `doorbell` output.
- R3: The read-only words and reserved words keep their value on a write. The read-only words are the identity (word 5) and the ring pointers (words 24..31 transmit, 32..39 receive). Reserved words read zero.
- R4: In the transmit halt word (word 2), queue q's halt flag sits at bit 31-q. A write with bit 31-q set produces a one-cycle `tx_kick[q]` in the cycle after the write, whatever the flag held. It also clears the flag.
- R5: In the receive halt word (word 3), queue q's flag sits at bit 23-q. A write with bit 23-q set clears the flag. It raises a one-cycle `rx_kick[q]` only if that flag was 0 before the write.
- R6: A write to a transmit base (words 8..15) or a receive base (words 16..23) for queue q stores the value with bits 2:0 forced to 0. It copies the same value into that queue's ring pointer word and pointer output.
- R7: The event register (word 0) is write-one-to-clear. Bit 0 is transmit-frame, bit 1 is receive-frame, and bits 31:2 are the error class. The interrupt mask is word 1. `irq_tx` is high when bit 0 is set in both the event and mask registers, and `irq_rx` likewise for bit 1. `irq_err` is high when any bit 31:2 is set in both. Each line drops once its events are cleared.
- R8: An `ev_set` strobe bit sets the matching event bit. If a strobe and a clear hit the same bit in one cycle, the bit ends up set.
- R9: A `tx_halt_set[q]` or `rx_halt_set[q]` strobe sets that queue's halt flag. A strobe wins over a same-cycle clear, though the kick rule of R4/R5 still applies.
- R10: A read returns its data on `bus_rdata` in the cycle after `bus_rd`. Scratch (word 4), mask and base words read back what was written (the bases after masking).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Byte address; word index is bits AW-1:2 |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| ev_set | input | 32 | Event set strobes from the datapath |
| tx_halt_set | input | NQ | Transmit queue halt strobes |
| rx_halt_set | input | NQ | Receive queue halt strobes |
| tx_kick | output | NQ | One-cycle transmit ring kicks |
| rx_kick | output | NQ | One-cycle receive ring kicks |
| tx_ring_ptr | output | NQ*32 | Transmit ring pointers, queue q at bits q*32+31:q*32 |
| rx_ring_ptr | output | NQ*32 | Receive ring pointers, same packing |
| doorbell | output | 32 | Last value written to the doorbell |
| irq_tx | output | 1 | Transmit-frame interrupt |
| irq_rx | output | 1 | Receive-frame interrupt |
| irq_err | output | 1 | Error-class interrupt |

## Verification
The assertions check the following on every cycle:
- each transmit kick follows its written halt bit;
- no kick appears without a write to the halt words;
- a receive kick never appears for an unwritten bit;
- a base write lands masked on the pointer output;
- event strobes always leave their bits set;
- a doorbell read returns zero.

Some behaviour depends on history, so only the bench's scenarios can show it:
- a receive kick suppressed because its flag was already set;
- set-over-clear priority on events and halt flags;
- interrupt grouping under changing masks;
- read-only and reserved words surviving writes.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  localparam int DW        = 32;
  localparam int W_EVT     = 0;
  localparam int W_MASK    = 1;
  localparam int W_TXST    = 2;
  localparam int W_RXST    = 3;
  localparam int W_SCR     = 4;
  localparam int W_ID      = 5;
  localparam int W_BELL    = 6;
  localparam int W_TXB     = 8;
  localparam int W_RXB     = 16;
  localparam int W_TXP     = 24;
  localparam int W_RXP     = 32;
  localparam int TX_HALT_MSB = 31;
  localparam int RX_HALT_MSB = 23;
  localparam int EV_TXF    = 0;
  localparam int EV_RXF    = 1;

  typedef enum logic [1:0] {ACC_RW, ACC_WO, ACC_RO, ACC_W1C} acc_e;

  function automatic acc_e acc_of(input int idx, input int nq);
    if (idx == W_EVT || idx == W_TXST || idx == W_RXST) return ACC_W1C;
    if (idx == W_MASK || idx == W_SCR) return ACC_RW;
    if (idx == W_BELL) return ACC_WO;
    if (idx >= W_TXB && idx < W_TXB + nq) return ACC_RW;
    if (idx >= W_RXB && idx < W_RXB + nq) return ACC_RW;
    return ACC_RO;
  endfunction
endpackage

// File: rtl/dmaq_halt.sv
module dmaq_halt #(
  parameter int NQ       = 8,
  parameter int MSB      = 31,
  parameter bit ONLY_NEW = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [31:0]   wdata,
  input  logic [NQ-1:0] set_in,
  output logic [NQ-1:0] halt,
  output logic [NQ-1:0] kick
);
  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic hit;
    assign hit = wr & wdata[MSB-q];
    always_ff @(posedge clk) begin
      if (rst) begin
        halt[q] <= 1'b0;
        kick[q] <= 1'b0;
      end else begin
        halt[q] <= set_in[q] | (halt[q] & ~hit);
        if (ONLY_NEW) kick[q] <= hit & ~halt[q];
        else          kick[q] <= hit;
      end
    end
  end
endmodule

// File: rtl/dmaq_ring.sv
module dmaq_ring #(
  parameter int NQ = 8,
  parameter int DW = 32,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [QW-1:0]  sel,
  input  logic [DW-1:0]  wdata,
  output logic [NQ*DW-1:0] base_o,
  output logic [NQ*DW-1:0] ptr_o
);
  logic [DW-1:0] masked;
  assign masked = {wdata[DW-1:3], 3'b000};

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [DW-1:0] base_q, ptr_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q <= '0;
        ptr_q  <= '0;
      end else if (wr && sel == QW'(q)) begin
        base_q <= masked;
        ptr_q  <= masked;
      end
    end
    assign base_o[q*DW +: DW] = base_q;
    assign ptr_o[q*DW +: DW]  = ptr_q;
  end
endmodule

// File: rtl/dmaq_evt.sv
module dmaq_evt #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_wr,
  input  logic          mask_wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] ev_set,
  output logic [DW-1:0] evt_o,
  output logic [DW-1:0] mask_o,
  output logic          irq_tx,
  output logic          irq_rx,
  output logic          irq_err
);
  logic [DW-1:0] evt_d, mask_d, act;

  always_comb begin
    evt_d  = (evt_o & ~(clr_wr ? wdata : '0)) | ev_set;
    mask_d = mask_wr ? wdata : mask_o;
    act    = evt_d & mask_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_o   <= '0;
      mask_o  <= '0;
      irq_tx  <= 1'b0;
      irq_rx  <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      evt_o   <= evt_d;
      mask_o  <= mask_d;
      irq_tx  <= act[dmaq_pkg::EV_TXF];
      irq_rx  <= act[dmaq_pkg::EV_RXF];
      irq_err <= |act[DW-1:2];
    end
  end
endmodule

// File: rtl/dmaq_regfile.sv
module dmaq_regfile #(
  parameter int          NQ       = 8,
  parameter int          AW       = 12,
  parameter logic [31:0] ID_VALUE = 32'h0D3A_0102
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  input  logic             bus_rd,
  output logic [31:0]      bus_rdata,
  input  logic [31:0]      ev_set,
  input  logic [NQ-1:0]    tx_halt_set,
  input  logic [NQ-1:0]    rx_halt_set,
  output logic [NQ-1:0]    tx_kick,
  output logic [NQ-1:0]    rx_kick,
  output logic [NQ*32-1:0] tx_ring_ptr,
  output logic [NQ*32-1:0] rx_ring_ptr,
  output logic [31:0]      doorbell,
  output logic             irq_tx,
  output logic             irq_rx,
  output logic             irq_err
);
  import dmaq_pkg::*;
  localparam int WI = AW - 2;
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1;

  logic [WI-1:0] widx, off_tb, off_rb, off_tp, off_rp;
  logic [31:0]   evt_q, mask_q, scratch_q, rd_val;
  logic [NQ-1:0] tx_halt, rx_halt;
  logic [NQ*32-1:0] tx_base, rx_base;
  logic in_tb, in_rb, in_tp, in_rp;

  assign widx   = bus_addr[AW-1:2];
  assign off_tb = widx - WI'(W_TXB);
  assign off_rb = widx - WI'(W_RXB);
  assign off_tp = widx - WI'(W_TXP);
  assign off_rp = widx - WI'(W_RXP);
  assign in_tb  = (widx >= WI'(W_TXB)) && (off_tb < WI'(NQ));
  assign in_rb  = (widx >= WI'(W_RXB)) && (off_rb < WI'(NQ));
  assign in_tp  = (widx >= WI'(W_TXP)) && (off_tp < WI'(NQ));
  assign in_rp  = (widx >= WI'(W_RXP)) && (off_rp < WI'(NQ));

  dmaq_halt #(.NQ(NQ), .MSB(TX_HALT_MSB), .ONLY_NEW(1'b0)) u_txh (
    .clk(clk), .rst(rst), .wr(bus_wr && widx == WI'(W_TXST)), .wdata(bus_wdata),
    .set_in(tx_halt_set), .halt(tx_halt), .kick(tx_kick));

  dmaq_halt #(.NQ(NQ), .MSB(RX_HALT_MSB), .ONLY_NEW(1'b1)) u_rxh (
    .clk(clk), .rst(rst), .wr(bus_wr && widx == WI'(W_RXST)), .wdata(bus_wdata),
    .set_in(rx_halt_set), .halt(rx_halt), .kick(rx_kick));

  dmaq_ring #(.NQ(NQ), .DW(32)) u_txr (
    .clk(clk), .rst(rst), .wr(bus_wr && in_tb), .sel(off_tb[QW-1:0]),
    .wdata(bus_wdata), .base_o(tx_base), .ptr_o(tx_ring_ptr));

  dmaq_ring #(.NQ(NQ), .DW(32)) u_rxr (
    .clk(clk), .rst(rst), .wr(bus_wr && in_rb), .sel(off_rb[QW-1:0]),
    .wdata(bus_wdata), .base_o(rx_base), .ptr_o(rx_ring_ptr));

  dmaq_evt #(.DW(32)) u_evt (
    .clk(clk), .rst(rst),
    .clr_wr(bus_wr && widx == WI'(W_EVT)), .mask_wr(bus_wr && widx == WI'(W_MASK)),
    .wdata(bus_wdata), .ev_set(ev_set), .evt_o(evt_q), .mask_o(mask_q),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err));

  always_ff @(posedge clk) begin
    if (rst) begin
      scratch_q <= '0;
      doorbell  <= '0;
    end else if (bus_wr) begin
      if (widx == WI'(W_SCR))  scratch_q <= bus_wdata;
      if (widx == WI'(W_BELL)) doorbell  <= bus_wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (widx == WI'(W_EVT))       rd_val = evt_q;
    else if (widx == WI'(W_MASK)) rd_val = mask_q;
    else if (widx == WI'(W_SCR))  rd_val = scratch_q;
    else if (widx == WI'(W_ID))   rd_val = ID_VALUE;
    else if (widx == WI'(W_BELL)) rd_val = doorbell;
    else if (widx == WI'(W_TXST)) begin
      for (int q = 0; q < NQ; q++) rd_val[TX_HALT_MSB-q] = tx_halt[q];
    end else if (widx == WI'(W_RXST)) begin
      for (int q = 0; q < NQ; q++) rd_val[RX_HALT_MSB-q] = rx_halt[q];
    end
    else if (in_tb) rd_val = tx_base[off_tb[QW-1:0]*32 +: 32];
    else if (in_rb) rd_val = rx_base[off_rb[QW-1:0]*32 +: 32];
    else if (in_tp) rd_val = tx_ring_ptr[off_tp[QW-1:0]*32 +: 32];
    else if (in_rp) rd_val = rx_ring_ptr[off_rp[QW-1:0]*32 +: 32];
    if (acc_of(int'(widx), NQ) == ACC_WO) rd_val = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/dmaq_regfile_chk.sv
module dmaq_regfile_chk #(
  parameter int NQ = 8,
  parameter int AW = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_wr,
  input logic [31:0]      bus_wdata,
  input logic             bus_rd,
  input logic [31:0]      bus_rdata,
  input logic [31:0]      ev_set,
  input logic [NQ-1:0]    tx_kick,
  input logic [NQ-1:0]    rx_kick,
  input logic [NQ*32-1:0] tx_ring_ptr,
  input logic [NQ*32-1:0] rx_ring_ptr,
  input logic [31:0]      evt_q
);
  localparam int WI = AW - 2;
  logic [WI-1:0] cw;
  assign cw = bus_addr[AW-1:2];

  p_kick_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && cw == WI'(dmaq_pkg::W_TXST)) |=> tx_kick == '0);

  p_rx_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && cw == WI'(dmaq_pkg::W_RXST)) |=> rx_kick == '0);

  for (genvar q = 0; q < NQ; q++) begin : g_q
    p_tx_kick_r4: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && cw == WI'(dmaq_pkg::W_TXST)) |=> tx_kick[q] == $past(bus_wdata[31-q]));

    p_rx_kick_r5: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && cw == WI'(dmaq_pkg::W_RXST) && !bus_wdata[23-q]) |=> !rx_kick[q]);

    p_txptr_r6: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && cw == WI'(dmaq_pkg::W_TXB + q)) |=>
        tx_ring_ptr[q*32 +: 32] == {$past(bus_wdata[31:3]), 3'b000});

    p_rxptr_r6: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && cw == WI'(dmaq_pkg::W_RXB + q)) |=>
        rx_ring_ptr[q*32 +: 32] == {$past(bus_wdata[31:3]), 3'b000});
  end

  p_evt_set_r8: assert property (@(posedge clk) disable iff (rst)
    (ev_set != '0) |=> (evt_q & $past(ev_set)) == $past(ev_set));

  p_wo_read_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && cw == WI'(dmaq_pkg::W_BELL)) |=> bus_rdata == '0);
endmodule

bind dmaq_regfile dmaq_regfile_chk #(.NQ(NQ), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .ev_set(ev_set), .tx_kick(tx_kick),
  .rx_kick(rx_kick), .tx_ring_ptr(tx_ring_ptr), .rx_ring_ptr(rx_ring_ptr), .evt_q(evt_q));

// File: tb/dmaq_regfile_bench.sv
module dmaq_regfile_bench;
  localparam int NQ = 8;
  localparam int AW = 12;
  localparam logic [31:0] IDV = 32'h0D3A_0102;

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata, ev_set = '0, doorbell;
  logic [NQ-1:0] tx_halt_set = '0, rx_halt_set = '0, tx_kick, rx_kick;
  logic [NQ*32-1:0] tx_ring_ptr, rx_ring_ptr;
  logic irq_tx, irq_rx, irq_err;

  always #10 clk = ~clk;

  dmaq_regfile #(.NQ(NQ), .AW(AW), .ID_VALUE(IDV)) u_dmaq_regfile (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [31:0] m_evt = 0, m_mask = 0, m_scr = 0, m_bell = 0;
  logic [NQ-1:0] m_tx = 0, m_rx = 0;
  logic [31:0] m_tb [NQ], m_rb [NQ];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(int idx);
    logic [31:0] v = '0;
    if (idx == 0) v = m_evt;
    else if (idx == 1) v = m_mask;
    else if (idx == 2) begin for (int q = 0; q < NQ; q++) v[31-q] = m_tx[q]; end
    else if (idx == 3) begin for (int q = 0; q < NQ; q++) v[23-q] = m_rx[q]; end
    else if (idx == 4) v = m_scr;
    else if (idx == 5) v = IDV;
    else if (idx >= 8 && idx < 8 + NQ) v = m_tb[idx-8];
    else if (idx >= 16 && idx < 16 + NQ) v = m_rb[idx-16];
    else if (idx >= 24 && idx < 24 + NQ) v = m_tb[idx-24];
    else if (idx >= 32 && idx < 32 + NQ) v = m_rb[idx-32];
    return v;
  endfunction

  task automatic cyc(bit wr, int idx, logic [31:0] d, bit rd, logic [31:0] ev,
                     logic [NQ-1:0] ths, logic [NQ-1:0] rhs);
    logic [NQ-1:0] etk = '0, erk = '0;
    logic [31:0] erd, act;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = AW'(idx * 4); bus_wdata = d;
    ev_set = ev; tx_halt_set = ths; rx_halt_set = rhs;
    erd = m_read(idx);
    if (wr) begin
      for (int q = 0; q < NQ; q++) begin
        if (idx == 2) etk[q] = d[31-q];
        if (idx == 3) erk[q] = d[23-q] & ~m_rx[q];
      end
      if (idx == 0) m_evt = m_evt & ~d;
      if (idx == 1) m_mask = d;
      if (idx == 2) for (int q = 0; q < NQ; q++) if (d[31-q]) m_tx[q] = 1'b0;
      if (idx == 3) for (int q = 0; q < NQ; q++) if (d[23-q]) m_rx[q] = 1'b0;
      if (idx == 4) m_scr = d;
      if (idx == 6) m_bell = d;
      if (idx >= 8 && idx < 8 + NQ) m_tb[idx-8] = {d[31:3], 3'b000};
      if (idx >= 16 && idx < 16 + NQ) m_rb[idx-16] = {d[31:3], 3'b000};
    end
    m_evt = m_evt | ev;
    m_tx = m_tx | ths;
    m_rx = m_rx | rhs;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; ev_set = '0; tx_halt_set = '0; rx_halt_set = '0;
    check("R4 tx_kick", 32'(tx_kick), 32'(etk));
    check("R5 rx_kick", 32'(rx_kick), 32'(erk));
    act = m_evt & m_mask;
    check("R7 irq", {29'd0, irq_err, irq_rx, irq_tx}, {29'd0, |act[31:2], act[1], act[0]});
    check("R2 doorbell", doorbell, m_bell);
    if (rd) check($sformatf("R10 read word %0d", idx), bus_rdata, erd);
    if (wr && ((idx >= 8 && idx < 8 + NQ) || (idx >= 16 && idx < 16 + NQ))) begin
      for (int q = 0; q < NQ; q++) begin
        check("R6 tx_ring_ptr", tx_ring_ptr[q*32 +: 32], m_tb[q]);
        check("R6 rx_ring_ptr", rx_ring_ptr[q*32 +: 32], m_rb[q]);
      end
    end
  endtask

  task automatic wr(int idx, logic [31:0] d); cyc(1, idx, d, 0, 0, 0, 0); endtask
  task automatic rd(int idx); cyc(0, idx, 0, 1, 0, 0, 0); endtask

  initial begin
    for (int q = 0; q < NQ; q++) begin m_tb[q] = 0; m_rb[q] = 0; end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 irq/kick", {irq_err, irq_rx, irq_tx, 8'(tx_kick), 8'(rx_kick)}, 0);
    for (int i = 0; i < 40; i++) rd(i);
    check("R1 doorbell", doorbell, 0);
    // R2: write-only doorbell
    wr(6, 32'hCAFE_F00D); rd(6);
    // R3: read-only / reserved ignore writes
    wr(5, 32'h1234_5678); rd(5);
    wr(7, 32'hFFFF_FFFF); rd(7);
    wr(26, 32'hFFFF_FFF0); rd(26);
    wr(300, 32'hA5A5_A5A5); rd(300);
    // R6: base masking and pointer copy
    wr(9, 32'h1000_00FF); rd(9); rd(25);
    wr(23, 32'hFFFF_FFFF); rd(23); rd(39);
    // R9 + R4: halt strobe then tx write kicks even when halted
    cyc(0, 0, 0, 0, 0, 8'h81, 8'h42); rd(2); rd(3);
    wr(2, 32'h8100_0000); rd(2);
    // R5: rx kick only for flags previously clear (queue 1 set, queue 2 clear)
    wr(3, 32'h0060_0000); rd(3);
    // R9: set wins over same-cycle clear
    cyc(1, 2, 32'h4000_0000, 0, 0, 8'h02, 0); rd(2);
    // R7/R8: event grouping, masking, set wins over clear
    wr(1, 32'h0000_0007);
    cyc(0, 0, 0, 0, 32'h0000_0005, 0, 0); rd(0);
    cyc(1, 0, 32'h0000_0001, 0, 32'h0000_0001, 0, 0); rd(0);
    wr(0, 32'hFFFF_FFFF); rd(0);
    cyc(0, 0, 0, 0, 32'h8000_0000, 0, 0);
    wr(1, 32'h8000_0000); wr(0, 32'h8000_0000);
    wr(4, 32'hDEAD_BEEF); rd(4);
    // random phase
    for (int n = 0; n < 1500; n++) begin
      int idx = int'($urandom_range(0, 41));
      logic [31:0] ev = ($urandom % 4 == 0) ? ($urandom & $urandom) : 0;
      logic [NQ-1:0] th = ($urandom % 5 == 0) ? NQ'($urandom) : '0;
      logic [NQ-1:0] rh = ($urandom % 5 == 0) ? NQ'($urandom) : '0;
      if ($urandom % 2) cyc(1, idx, $urandom, 0, ev, th, rh);
      else              cyc(0, idx, 0, 1, ev, th, rh);
    end
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule